// File: doc/BRIEF.md
# Serial Video Deframing Receiver

This block sits behind clock and data recovery in a serial digital video receiver. It takes one recovered line bit on each bit clock, undoes the NRZI line code, and then removes the self-synchronising scrambling. It then hunts the recovered bit stream for the timing reference preamble. The preamble is a word of all ones followed by two all-zero words. The bit position at which the preamble ends becomes the word boundary. From then on the block delivers one 10-bit parallel word for every ten bit clocks, with a one-cycle strobe.

A single bypass input switches off the NRZI decoder and the descrambler together, so that raw line bits go straight to the framer. A sticky flag reports that framing has been acquired. A pulse reports that a later preamble arrived at a different bit offset and that the block has moved its word boundary to that offset.

Top module: `vidrx_deframer`

## Requirements
- R1: With bypass low, each recovered bit is n(t) ^ n(t-4) ^ n(t-9), where n(t) = line(t) ^ line(t-1) is the NRZI-decoded bit. Decoding is NRZI first, then descrambling.
- R2: With bypass high, the raw line bit is used directly, with no NRZI decoding and no descrambling.
- R3: Words are 10 bits wide and assembled LSB first, so the earliest received bit becomes bit 0. Once framed, exactly one word is delivered every 10 bit clocks.
- R4: The preamble is matched on 30 consecutive recovered bits: 3FF, then 000, then 000, each word LSB first. The clock that completes the match delivers the final 000 word. The following bit is bit 0 of a new word.
- R5: The word strobe stays low until the first preamble match.
- R6: If a preamble match completes at a bit offset other than the current word boundary, the block moves its boundary to the new offset. It raises the realign output for one cycle, together with the word strobe.
- R7: The aligned output rises with the first preamble match and then stays high until reset.
- R8: While reset (active low) is asserted, the strobe, aligned and realign outputs are low. Reset also clears the descrambler history and the NRZI previous bit, so a preamble sent immediately after reset is framed correctly.
- R9: A preamble that repeats on the current word boundary does not pulse realign.
- R10: With bypass low, inverting the line polarity does not change the recovered words once the decoder history has refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Recovered serial line bit |
| bypass | input | 1 | High: pass raw bits, skip NRZI decoding and descrambling |
| wordOut | output | 10 | Framed parallel word, LSB first in time |
| wordValid | output | 1 | One-cycle strobe, wordOut is new |
| aligned | output | 1 | Framing acquired since reset (sticky) |
| realign | output | 1 | One-cycle pulse: word boundary moved |

## Verification
The bench encodes its own payload with the matching scrambler and NRZI coder. It checks for the 000 word delivered on the match clock, followed by the payload in order. A design with the wrong bit order or the wrong tap positions would return garbled words. A design that restarts its word counter one bit late or early would return words shifted by one bit. A preamble that repeats on the current boundary checks that realign stays quiet. A preamble shifted by three bits checks that the boundary really moves. Two further scenarios are sent straight after a reset: one uses an inverted line polarity, and the other has no leading filler. A design that keeps stale decoder history, or that depends on line polarity, would lose or corrupt the first words in these cases.

// File: rtl/vidrx_pkg.sv
package vidrx_pkg;
  // strobes from the framing control to the word datapath
  typedef struct packed {
    logic emit;     // capture the word completed by this bit
    logic realign;  // boundary moved on this bit
  } ctlStrobe_t;
endpackage

// File: rtl/vidrx_decode.sv
module vidrx_decode #(
  parameter int TAP_A = 4,
  parameter int TAP_B = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineBit,
  input  logic bypass,
  output logic outBit
);
  localparam int HIST_W = TAP_B;

  logic              prevLine;
  logic [HIST_W-1:0] hist;     // hist[0] is the previous NRZI-decoded bit
  logic              nrziBit;
  logic              descBit;

  assign nrziBit = lineBit ^ prevLine;
  assign descBit = nrziBit ^ hist[TAP_A-1] ^ hist[TAP_B-1];
  assign outBit  = bypass ? lineBit : descBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLine <= 1'b0;
      hist     <= '0;
    end else begin
      prevLine <= lineBit;
      hist     <= {hist[HIST_W-2:0], nrziBit};
    end
  end

endmodule

// File: rtl/vidrx_datapath.sv
module vidrx_datapath
  import vidrx_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int PRE_WORDS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inBit,
  input  ctlStrobe_t        ctl,
  output logic              match,
  output logic [WORD_W-1:0] wordOut
);
  localparam int PAT_W = WORD_W * PRE_WORDS;
  // LSB-first window: oldest bit lands in bit 0, so the all-ones word sits low
  localparam logic [PAT_W-1:0] PATTERN = {{(PAT_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

  logic [PAT_W-1:0]  window;
  logic [PAT_W-1:0]  nextWin;
  logic [WORD_W-1:0] wordSh;
  logic [WORD_W-1:0] nextWord;

  assign nextWin  = {inBit, window[PAT_W-1:1]};
  assign nextWord = {inBit, wordSh[WORD_W-1:1]};
  assign match    = (nextWin == PATTERN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      window  <= '0;
      wordSh  <= '0;
      wordOut <= '0;
    end else begin
      window <= nextWin;
      wordSh <= nextWord;
      if (ctl.emit) wordOut <= nextWord;
    end
  end

  AST_MATCH_GIVES_ZERO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    match |=> (wordOut == '0)); // R4

endmodule

// File: rtl/vidrx_ctrl.sv
module vidrx_ctrl
  import vidrx_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       match,
  output ctlStrobe_t ctl,
  output logic       wordValid,
  output logic       aligned,
  output logic       realign
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             wordEnd;

  assign wordEnd     = (bitCnt == LAST);
  assign ctl.emit    = match | (aligned & wordEnd);
  assign ctl.realign = match & aligned & ~wordEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      aligned   <= 1'b0;
      wordValid <= 1'b0;
      realign   <= 1'b0;
    end else begin
      bitCnt    <= (match || wordEnd) ? '0 : bitCnt + 1'b1;
      aligned   <= aligned | match;
      wordValid <= ctl.emit;
      realign   <= ctl.realign;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST); // R3
  AST_MATCH_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    match |=> wordValid); // R4
  AST_VALID_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> aligned); // R5
  AST_REALIGN_WITH_WORD: assert property (@(posedge clk) disable iff (!rstN)
    realign |-> wordValid); // R6
  AST_ALIGNED_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    aligned |=> aligned); // R7

endmodule

// File: rtl/vidrx_deframer.sv
module vidrx_deframer
  import vidrx_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int PRE_WORDS = 3,
  parameter int TAP_A     = 4,
  parameter int TAP_B     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bypass,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic              aligned,
  output logic              realign
);
  logic       recBit;
  logic       match;
  ctlStrobe_t ctl;

  vidrx_decode #(.TAP_A(TAP_A), .TAP_B(TAP_B)) uDecode (
    .clk(clk), .rstN(rstN), .lineBit(bitIn), .bypass(bypass), .outBit(recBit)
  );

  vidrx_datapath #(.WORD_W(WORD_W), .PRE_WORDS(PRE_WORDS)) uData (
    .clk(clk), .rstN(rstN), .inBit(recBit), .ctl(ctl),
    .match(match), .wordOut(wordOut)
  );

  vidrx_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .match(match), .ctl(ctl),
    .wordValid(wordValid), .aligned(aligned), .realign(realign)
  );

endmodule

// File: tb/tb_vidrx_deframer.sv
module tb_vidrx_deframer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitIn = 1'b0;
  logic       bypass = 1'b0;
  logic [9:0] wordOut;
  logic       wordValid, aligned, realign;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [8:0] scr = '0;   // bench scrambler history
  logic       line = 1'b0;
  logic [9:0] cap [0:511];
  int         capN = 0;
  int         realignCnt = 0;
  logic [9:0] pay [0:4] = '{10'h123, 10'h2AA, 10'h0F0, 10'h155, 10'h301};

  vidrx_deframer dut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bypass(bypass),
    .wordOut(wordOut), .wordValid(wordValid), .aligned(aligned), .realign(realign)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic x);
    logic s;
    if (bypass) bitIn = x;
    else begin
      s = x ^ scr[3] ^ scr[8];
      scr = {scr[7:0], s};
      line = line ^ s;
      bitIn = line;
    end
    @(posedge clk); #1;
    if (wordValid && capN < 512) begin cap[capN] = wordOut; capN++; end
    if (realign) realignCnt++;
  endtask

  task automatic sendWord(input logic [9:0] w);
    for (int i = 0; i < 10; i++) sendBit(w[i]);
  endtask

  task automatic sendFrame(input int fillers);
    for (int i = 0; i < fillers; i++) sendWord(10'h2AA);
    sendWord(10'h3FF); sendWord(10'h000); sendWord(10'h000);
    for (int i = 0; i < 5; i++) sendWord(pay[i]);
  endtask

  task automatic checkTail(input string req);
    check(capN >= 6, req, capN, 6);
    if (capN >= 6) begin
      check(cap[capN-6] == 10'h000, req, cap[capN-6], 0);
      for (int i = 0; i < 5; i++) check(cap[capN-5+i] == pay[i], req, cap[capN-5+i], pay[i]);
    end
  endtask

  task automatic resetDut(input logic lineInit);
    rstN = 1'b0; scr = '0; line = lineInit; bitIn = lineInit;
    repeat (3) @(posedge clk); #1;
    check(!wordValid && !aligned && !realign, "R8 reset outputs", {wordValid, aligned, realign}, 0);
    rstN = 1'b1;
    bitIn = 1'b0; line = 1'b0;
    capN = 0; realignCnt = 0;
  endtask

  // R5: no strobe before any preamble
  task automatic testNoPreamble;
    resetDut(1'b0);
    for (int i = 0; i < 20; i++) sendWord(10'h2AA);
    check(capN == 0, "R5 no words before preamble", capN, 0);
    check(!aligned, "R7 aligned before preamble", aligned, 0);
  endtask

  // R1 R3 R4 R7 R9: frame, then a repeat on the same boundary
  task automatic testFrame;
    resetDut(1'b0);
    sendFrame(4);
    check(capN == 6, "R4 word count after first frame", capN, 6);
    checkTail("R1 R3 descrambled words");
    check(aligned, "R7 aligned set", aligned, 1);
    sendFrame(2);
    check(capN == 6 + 2 + 3 + 5, "R3 one word per ten bits", capN, 16);
    checkTail("R4 repeat frame words");
    check(realignCnt == 0, "R9 no realign on same offset", realignCnt, 0);
    check(aligned, "R7 aligned sticky", aligned, 1);
  endtask

  // R6: preamble moved by three bits
  task automatic testRealign;
    sendWord(10'h2AA);
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    sendFrame(1);
    check(realignCnt == 1, "R6 realign pulse count", realignCnt, 1);
    checkTail("R6 words after realign");
  endtask

  // R2: raw bits with bypass high
  task automatic testBypass;
    bypass = 1'b1;
    resetDut(1'b0);
    sendFrame(3);
    check(capN == 6, "R2 bypass word count", capN, 6);
    checkTail("R2 bypass words");
    bypass = 1'b0;
  endtask

  // R10: inverted line polarity
  task automatic testPolarity;
    resetDut(1'b0);
    line = 1'b1;
    sendFrame(3);
    checkTail("R10 inverted polarity");
  endtask

  // R8: history cleared, preamble immediately after reset
  task automatic testResetHistory;
    sendWord(10'h3A5);
    resetDut(1'b0);
    sendFrame(0);
    check(capN == 6, "R8 frame right after reset count", capN, 6);
    checkTail("R8 frame right after reset");
  endtask

  initial begin
    testNoPreamble();
    testFrame();
    testRealign();
    testBypass();
    testPolarity();
    testResetHistory();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule